// File: doc/BRIEF.md
# Interline CCD Timing Generator

This block is a synchronous sequencer that drives the clock phases of an interline-transfer CCD as logic levels. Every output is the digital intent of one drive line: the two vertical phase groups, the third-level transfer pulse, the left and right horizontal phase pairs, the last-stage horizontal clock, the output reset clock, the fast-dump gate and the substrate shutter pulse. Level shifting to analog voltages and the sampling of the video are done outside the block.

A frame starts with a pedestal. Both vertical groups sit at the middle level, and inside the pedestal a transfer pulse moves photodiode charge into the vertical registers. After a settling delay the block runs one line period per row. Each line has a vertical shift, a delay, and then a burst of horizontal pixel periods. The burst is long in single-tap mode and about half as long in dual-tap mode, where the right register shifts toward its own output. A programmable row range can discard its rows through the dump gate. One selected row can carry the shutter pulse, which starts integration for the next frame.

All durations come in as counts of reference-clock cycles. Any count below its floor is raised to that floor. The run input is looked at only between frames. Start-of-frame and start-of-line strobes are provided for the capture logic downstream.

Top module: `ccd_tgen`

## Requirements
- R1: After reset, and while idle, `vphi1` is 1 and every other output is 0. No frame starts while `run` is 0.
- R2: A frame opens with a one-cycle `sof` and a pedestal in which `vphi1` and `vphi2` are both 1 for `t_ped_lead + t_xfer + t_ped_tail` cycles. `vphi2_xfer` is 1 for exactly `t_xfer` cycles, and only inside the pedestal.
- R3: After the pedestal ends, `t_first` cycles pass before the first `sol`. Each frame has exactly N_LINES `sol` strobes, and no horizontal clock or transfer pulse is active while `sol` is high.
- R4: Each line shifts vertically by holding `vphi2`=1 and `vphi1`=0 for `t_vshift` cycles. The two vertical groups are never both 0.
- R5: On a line with neither dump nor shutter, `t_hdelay` cycles pass from the end of the vertical shift to the first `hphi1_l` cycle.
- R6: A line carries PIX_SINGLE pixel periods when `dual_tap`=0 and PIX_DUAL when `dual_tap`=1. Each pixel period is `t_pix_half` cycles of `hphi1_l`, then `t_pix_half` cycles of `hphi2_l`. `hlast` equals `hphi2_l`, and the two phases are never high together.
- R7: `hreset` is a one-cycle pulse on the first cycle of each pixel period, so it comes once per pixel.
- R8: When `dual_tap`=0, `hphi1_r`/`hphi2_r` equal `hphi1_l`/`hphi2_l`. When `dual_tap`=1 they are swapped: `hphi1_r`=`hphi2_l` and `hphi2_r`=`hphi1_l`.
- R9: When `dump_en`=1, every line index in `dump_first..dump_last` (line 0 is the first line of the frame) raises `dump_gate` `t_dump_edge` cycles before its vertical shift and lowers it `t_dump_edge` cycles after, giving a pulse of `2*t_dump_edge + t_vshift` cycles. `t_hdelay` then follows before the burst. No other line raises `dump_gate`.
- R10: When `shut_en`=1, line `shut_line` carries one `sub_pulse` of `t_shut_width` cycles. It starts `t_shut_delay` cycles after the vertical shift ends, or after the dump trailing edge on a dumped line. The burst starts `t_shut_guard` cycles after the pulse; this replaces `t_hdelay`. No other line carries the pulse.
- R11: Each duration below its floor acts as the floor. The floors are MIN_VSHIFT, MIN_HDELAY, MIN_XFER, MIN_FIRST, MIN_SHUT_W and MIN_SHUT_GUARD, and 1 for every other duration.
- R12: `run` is sampled only when the last line of a frame completes. A frame in progress always runs to its end. A new frame follows at once if `run` is 1; otherwise the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start/continue framing, sampled between frames |
| dual_tap | input | 1 | 1 = two-output readout, right register reversed |
| dump_en | input | 1 | Enable fast dump on the row range |
| dump_first | input | LINE_W | First line index to dump |
| dump_last | input | LINE_W | Last line index to dump |
| shut_en | input | 1 | Enable the shutter pulse |
| shut_line | input | LINE_W | Line index carrying the shutter pulse |
| t_vshift | input | CNT_W | Vertical shift length |
| t_hdelay | input | CNT_W | Shift-to-burst delay |
| t_xfer | input | CNT_W | Photodiode transfer pulse length |
| t_ped_lead | input | CNT_W | Pedestal time before the transfer pulse |
| t_ped_tail | input | CNT_W | Pedestal time after the transfer pulse |
| t_first | input | CNT_W | Pedestal-to-first-line delay |
| t_dump_edge | input | CNT_W | Dump gate lead and trail around the shift |
| t_shut_delay | input | CNT_W | Shift end to shutter pulse |
| t_shut_width | input | CNT_W | Shutter pulse width |
| t_shut_guard | input | CNT_W | Shutter pulse to burst |
| t_pix_half | input | CNT_W | Half of a pixel period |
| vphi1 | output | 1 | Vertical group 1 (1 = middle, 0 = low) |
| vphi2 | output | 1 | Vertical group 2 (1 = middle, 0 = low) |
| vphi2_xfer | output | 1 | Vertical group 2 third-level transfer pulse |
| hphi1_l | output | 1 | Left horizontal phase 1 |
| hphi2_l | output | 1 | Left horizontal phase 2 |
| hphi1_r | output | 1 | Right horizontal phase 1 |
| hphi2_r | output | 1 | Right horizontal phase 2 |
| hlast | output | 1 | Last-stage horizontal clock |
| hreset | output | 1 | Output-node reset clock |
| dump_gate | output | 1 | Fast line dump gate |
| sub_pulse | output | 1 | Electronic shutter substrate pulse |
| sof | output | 1 | Start-of-frame strobe |
| sol | output | 1 | Start-of-line strobe |

## Verification
The bench builds the block with N_LINES=4, PIX_SINGLE=5, PIX_DUAL=3, CNT_W=8 and floors of a few cycles. With these values it observes every line of whole frames and can count each pixel period. The first run is single-tap with durations above their floors, a dump on the second line and the shutter on the third, and two frames back to back. The second run is dual-tap with every duration programmed to zero, which puts the floors in force. In that run the dump falls on the first line and the shutter on the last line, so both edges of the row range and the stop-between-frames behaviour are covered.

// File: rtl/ccd_tgen_pkg.sv
// Shared indices and sequencer state encoding for the CCD timing generator.
package ccd_tgen_pkg;
    localparam int NDUR     = 11;
    localparam int D_VX     = 0;
    localparam int D_HD     = 1;
    localparam int D_PD     = 2;
    localparam int D_PLEAD  = 3;
    localparam int D_PTAIL  = 4;
    localparam int D_FIRST  = 5;
    localparam int D_FD     = 6;
    localparam int D_SHD    = 7;
    localparam int D_SH     = 8;
    localparam int D_SHPOST = 9;
    localparam int D_HALF   = 10;

    typedef enum logic [3:0] {
        S_IDLE, S_PEDA, S_PDX, S_PEDB, S_FIRST,
        S_FDL, S_VSH, S_FDT, S_HDLY,
        S_SHP, S_SHON, S_SHQ, S_HB
    } seq_state_t;
endpackage

// File: rtl/ccd_tgen_clamp.sv
// Raises each programmed duration to its floor.
// Assumes: FLOOR entries are at least 1 so that every timed state lasts a cycle.
module ccd_tgen_clamp
    import ccd_tgen_pkg::*;
#(
    parameter int W = 16,
    parameter logic [NDUR-1:0][W-1:0] FLOOR = '0
) (
    input  logic [NDUR-1:0][W-1:0] raw,
    output logic [NDUR-1:0][W-1:0] eff
);
    for (genvar i = 0; i < NDUR; i++) begin : g_cl
        // Per-duration floor selection.
        assign eff[i] = (raw[i] < FLOOR[i]) ? FLOOR[i] : raw[i];
    end
endmodule

// File: rtl/ccd_tgen_hclk.sv
// Horizontal pixel engine: while active, produces pixel periods of two equal
// halves and flags the last cycle of the last pixel.
// Assumes: half >= 1; counters restart whenever active drops.
module ccd_tgen_hclk #(
    parameter int W          = 16,
    parameter int PIX_SINGLE = 4972,
    parameter int PIX_DUAL   = 2492,
    localparam int PIX_MAX   = (PIX_SINGLE > PIX_DUAL) ? PIX_SINGLE : PIX_DUAL,
    localparam int PW        = (PIX_MAX > 1) ? $clog2(PIX_MAX) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         dual,
    input  logic [W-1:0] half,
    output logic         h1,
    output logic         h2,
    output logic         h1r,
    output logic         h2r,
    output logic         rpulse,
    output logic         done
);
    logic [W-1:0]  hc;
    logic          ph;
    logic [PW-1:0] pc;
    logic          last_half;
    logic [PW-1:0] pix_last;

    assign last_half = (hc == half - 1'b1);
    assign pix_last  = dual ? PW'(PIX_DUAL - 1) : PW'(PIX_SINGLE - 1);

    // Half-period, phase and pixel counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            hc <= '0;
            ph <= 1'b0;
            pc <= '0;
        end else if (last_half) begin
            hc <= '0;
            ph <= ~ph;
            if (ph) pc <= pc + 1'b1;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    // Phase decode, reset pulse and right-tap phase selection.
    always_comb begin
        h1     = active & ~ph;
        h2     = active & ph;
        rpulse = active & ~ph & (hc == '0);
        done   = active & ph & last_half & (pc == pix_last);
        h1r    = dual ? h2 : h1;
        h2r    = dual ? h1 : h2;
    end
endmodule

// File: rtl/ccd_tgen_seq.sv
// Frame/line sequencer: pedestal with transfer pulse, first-line delay, then
// per line optional dump lead, vertical shift, optional dump trail, either the
// plain delay or the shutter window, and the horizontal burst.
// Assumes: all durations already clamped to >= 1; run is read only after the
// last burst of a frame or while idle.
module ccd_tgen_seq
    import ccd_tgen_pkg::*;
#(
    parameter int W          = 16,
    parameter int N_LINES    = 3324,
    parameter int PIX_SINGLE = 4972,
    parameter int PIX_DUAL   = 2492,
    localparam int LW        = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   dual,
    input  logic                   dump_en,
    input  logic [LW-1:0]          dump_first,
    input  logic [LW-1:0]          dump_last,
    input  logic                   shut_en,
    input  logic [LW-1:0]          shut_line,
    input  logic [NDUR-1:0][W-1:0] dur,
    output logic                   v1,
    output logic                   v2,
    output logic                   v2x,
    output logic                   fd,
    output logic                   sub,
    output logic                   h1,
    output logic                   h2,
    output logic                   h1r,
    output logic                   h2r,
    output logic                   rpulse,
    output logic                   sof,
    output logic                   sol
);
    seq_state_t    state, nxt;
    logic [W-1:0]  tmr, nload;
    logic [LW-1:0] line, nline;
    logic          dump_q, shut_q, ndump, nshut;
    logic          last_line, expire, hact, bdone;

    assign last_line = (line == LW'(N_LINES - 1));
    assign hact      = (state == S_HB);

    // Line index of the state being entered and its dump/shutter flags.
    always_comb begin
        if (state == S_FIRST)                 nline = '0;
        else if (state == S_HB && !last_line) nline = line + 1'b1;
        else                                  nline = line;
        ndump = dump_en && (nline >= dump_first) && (nline <= dump_last);
        nshut = shut_en && (nline == shut_line);
    end

    // Successor state and the moment to take it.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:  nxt = S_PEDA;
            S_PEDA:  nxt = S_PDX;
            S_PDX:   nxt = S_PEDB;
            S_PEDB:  nxt = S_FIRST;
            S_FIRST: nxt = ndump ? S_FDL : S_VSH;
            S_FDL:   nxt = S_VSH;
            S_VSH:   nxt = dump_q ? S_FDT : (shut_q ? S_SHP : S_HDLY);
            S_FDT:   nxt = shut_q ? S_SHP : S_HDLY;
            S_HDLY:  nxt = S_HB;
            S_SHP:   nxt = S_SHON;
            S_SHON:  nxt = S_SHQ;
            S_SHQ:   nxt = S_HB;
            S_HB:    nxt = last_line ? (run ? S_PEDA : S_IDLE)
                                     : (ndump ? S_FDL : S_VSH);
            default: nxt = S_IDLE;
        endcase
        case (state)
            S_IDLE:  expire = run;
            S_HB:    expire = bdone;
            default: expire = (tmr == '0);
        endcase
    end

    // Length of the state being entered.
    always_comb begin
        case (nxt)
            S_PEDA:  nload = dur[D_PLEAD];
            S_PDX:   nload = dur[D_PD];
            S_PEDB:  nload = dur[D_PTAIL];
            S_FIRST: nload = dur[D_FIRST];
            S_FDL:   nload = dur[D_FD];
            S_VSH:   nload = dur[D_VX];
            S_FDT:   nload = dur[D_FD];
            S_HDLY:  nload = dur[D_HD];
            S_SHP:   nload = dur[D_SHD];
            S_SHON:  nload = dur[D_SH];
            S_SHQ:   nload = dur[D_SHPOST];
            default: nload = W'(1);
        endcase
    end

    // State, timer, line index and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            tmr    <= '0;
            line   <= '0;
            dump_q <= 1'b0;
            shut_q <= 1'b0;
            sof    <= 1'b0;
            sol    <= 1'b0;
        end else begin
            sof <= 1'b0;
            sol <= 1'b0;
            if (expire) begin
                state  <= nxt;
                tmr    <= nload - 1'b1;
                line   <= nline;
                dump_q <= ndump;
                shut_q <= nshut;
                sof    <= (nxt == S_PEDA);
                sol    <= (nxt == S_FDL) || (nxt == S_VSH && state != S_FDL);
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    // Vertical, dump and shutter levels decoded from the state.
    always_comb begin
        v1  = (state != S_VSH);
        v2  = (state == S_VSH) || (state == S_PEDA) ||
              (state == S_PDX) || (state == S_PEDB);
        v2x = (state == S_PDX);
        fd  = (state == S_FDL) || (state == S_FDT) || (state == S_VSH && dump_q);
        sub = (state == S_SHON);
    end

    ccd_tgen_hclk #(
        .W(W), .PIX_SINGLE(PIX_SINGLE), .PIX_DUAL(PIX_DUAL)
    ) u_hclk (
        .clk(clk), .rst_n(rst_n), .active(hact), .dual(dual),
        .half(dur[D_HALF]), .h1(h1), .h2(h2), .h1r(h1r), .h2r(h2r),
        .rpulse(rpulse), .done(bdone)
    );
endmodule

// File: rtl/ccd_tgen.sv
// Top of the interline CCD timing generator: clamps the programmed durations,
// runs the sequencer and registers every output for glitch-free drive.
// Assumes: configuration inputs change only while the block is idle.
module ccd_tgen
    import ccd_tgen_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int N_LINES        = 3324,
    parameter int PIX_SINGLE     = 4972,
    parameter int PIX_DUAL       = 2492,
    parameter int MIN_VSHIFT     = 240,
    parameter int MIN_HDELAY     = 240,
    parameter int MIN_XFER       = 600,
    parameter int MIN_FIRST      = 720,
    parameter int MIN_SHUT_W     = 240,
    parameter int MIN_SHUT_GUARD = 360,
    localparam int LINE_W        = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dual_tap,
    input  logic              dump_en,
    input  logic [LINE_W-1:0] dump_first,
    input  logic [LINE_W-1:0] dump_last,
    input  logic              shut_en,
    input  logic [LINE_W-1:0] shut_line,
    input  logic [CNT_W-1:0]  t_vshift,
    input  logic [CNT_W-1:0]  t_hdelay,
    input  logic [CNT_W-1:0]  t_xfer,
    input  logic [CNT_W-1:0]  t_ped_lead,
    input  logic [CNT_W-1:0]  t_ped_tail,
    input  logic [CNT_W-1:0]  t_first,
    input  logic [CNT_W-1:0]  t_dump_edge,
    input  logic [CNT_W-1:0]  t_shut_delay,
    input  logic [CNT_W-1:0]  t_shut_width,
    input  logic [CNT_W-1:0]  t_shut_guard,
    input  logic [CNT_W-1:0]  t_pix_half,
    output logic              vphi1,
    output logic              vphi2,
    output logic              vphi2_xfer,
    output logic              hphi1_l,
    output logic              hphi2_l,
    output logic              hphi1_r,
    output logic              hphi2_r,
    output logic              hlast,
    output logic              hreset,
    output logic              dump_gate,
    output logic              sub_pulse,
    output logic              sof,
    output logic              sol
);
    localparam logic [NDUR-1:0][CNT_W-1:0] FLOORS = {
        CNT_W'(1),              // D_HALF
        CNT_W'(MIN_SHUT_GUARD), // D_SHPOST
        CNT_W'(MIN_SHUT_W),     // D_SH
        CNT_W'(1),              // D_SHD
        CNT_W'(1),              // D_FD
        CNT_W'(MIN_FIRST),      // D_FIRST
        CNT_W'(1),              // D_PTAIL
        CNT_W'(1),              // D_PLEAD
        CNT_W'(MIN_XFER),       // D_PD
        CNT_W'(MIN_HDELAY),     // D_HD
        CNT_W'(MIN_VSHIFT)      // D_VX
    };

    logic [NDUR-1:0][CNT_W-1:0] raw, eff;
    logic s_v1, s_v2, s_v2x, s_fd, s_sub, s_h1, s_h2, s_h1r, s_h2r, s_rp, s_sof, s_sol;

    // Gather the programmed durations into the indexed bank.
    always_comb begin
        raw[D_VX]     = t_vshift;
        raw[D_HD]     = t_hdelay;
        raw[D_PD]     = t_xfer;
        raw[D_PLEAD]  = t_ped_lead;
        raw[D_PTAIL]  = t_ped_tail;
        raw[D_FIRST]  = t_first;
        raw[D_FD]     = t_dump_edge;
        raw[D_SHD]    = t_shut_delay;
        raw[D_SH]     = t_shut_width;
        raw[D_SHPOST] = t_shut_guard;
        raw[D_HALF]   = t_pix_half;
    end

    ccd_tgen_clamp #(.W(CNT_W), .FLOOR(FLOORS)) u_clamp (.raw(raw), .eff(eff));

    ccd_tgen_seq #(
        .W(CNT_W), .N_LINES(N_LINES), .PIX_SINGLE(PIX_SINGLE), .PIX_DUAL(PIX_DUAL)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .dual(dual_tap),
        .dump_en(dump_en), .dump_first(dump_first), .dump_last(dump_last),
        .shut_en(shut_en), .shut_line(shut_line), .dur(eff),
        .v1(s_v1), .v2(s_v2), .v2x(s_v2x), .fd(s_fd), .sub(s_sub),
        .h1(s_h1), .h2(s_h2), .h1r(s_h1r), .h2r(s_h2r), .rpulse(s_rp),
        .sof(s_sof), .sol(s_sol)
    );

    // Output register stage; reset holds the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vphi1 <= 1'b1; vphi2 <= 1'b0; vphi2_xfer <= 1'b0;
            hphi1_l <= 1'b0; hphi2_l <= 1'b0; hphi1_r <= 1'b0; hphi2_r <= 1'b0;
            hlast <= 1'b0; hreset <= 1'b0; dump_gate <= 1'b0; sub_pulse <= 1'b0;
            sof <= 1'b0; sol <= 1'b0;
        end else begin
            vphi1 <= s_v1; vphi2 <= s_v2; vphi2_xfer <= s_v2x;
            hphi1_l <= s_h1; hphi2_l <= s_h2; hphi1_r <= s_h1r; hphi2_r <= s_h2r;
            hlast <= s_h2; hreset <= s_rp; dump_gate <= s_fd; sub_pulse <= s_sub;
            sof <= s_sof; sol <= s_sol;
        end
    end
endmodule

// File: rtl/ccd_tgen_chk.sv
// Port-level protocol checks for the CCD timing generator, bound to the top.
module ccd_tgen_chk (
    input logic clk,
    input logic rst_n,
    input logic vphi1,
    input logic vphi2,
    input logic vphi2_xfer,
    input logic hphi1_l,
    input logic hphi2_l,
    input logic hphi1_r,
    input logic hphi2_r,
    input logic hreset,
    input logic dump_gate,
    input logic sub_pulse,
    input logic sof,
    input logic sol
);
    p_vert_not_both_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vphi1 || vphi2) else $error("R4 both vertical groups low");

    p_xfer_in_pedestal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vphi2_xfer |-> (vphi1 && vphi2)) else $error("R2 transfer outside pedestal");

    p_sof_opens_pedestal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (vphi1 && vphi2 && !vphi2_xfer)) else $error("R2 sof without pedestal lead");

    p_sol_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sol |-> (!hphi1_l && !hphi2_l && !vphi2_xfer)) else $error("R3 sol during activity");

    p_h_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hphi1_l && hphi2_l)) else $error("R6 left phases overlap");

    p_hreset_in_h1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hreset |-> hphi1_l) else $error("R7 reset clock outside phase 1");

    p_hreset_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hreset |=> !hreset) else $error("R7 reset clock wider than one cycle");

    p_right_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hphi1_r && hphi2_r)) else $error("R8 right phases overlap");

    p_dump_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dump_gate |-> (!hphi1_l && !hphi2_l)) else $error("R9 dump during burst");

    p_shutter_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse |-> (vphi1 && !vphi2 && !hphi1_l && !hphi2_l))
        else $error("R10 shutter overlaps shift or burst");
endmodule

bind ccd_tgen ccd_tgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .vphi1(vphi1), .vphi2(vphi2), .vphi2_xfer(vphi2_xfer),
    .hphi1_l(hphi1_l), .hphi2_l(hphi2_l), .hphi1_r(hphi1_r), .hphi2_r(hphi2_r),
    .hreset(hreset), .dump_gate(dump_gate), .sub_pulse(sub_pulse), .sof(sof), .sol(sol)
);

// File: tb/ccd_tgen_bench.sv
`timescale 1ns/1ps
module ccd_tgen_bench;
    localparam int NL = 4, PS = 5, PD = 3, W = 8;
    localparam int F_VX = 3, F_HD = 2, F_PD = 2, F_FIRST = 3, F_SH = 2, F_SHQ = 3;

    logic clk = 0, rst_n = 0, run = 0, dual_tap = 0, dump_en = 0, shut_en = 0;
    logic [1:0] dump_first = 0, dump_last = 0, shut_line = 0;
    logic [W-1:0] t_vshift = 0, t_hdelay = 0, t_xfer = 0, t_ped_lead = 0, t_ped_tail = 0,
                  t_first = 0, t_dump_edge = 0, t_shut_delay = 0, t_shut_width = 0,
                  t_shut_guard = 0, t_pix_half = 0;
    logic vphi1, vphi2, vphi2_xfer, hphi1_l, hphi2_l, hphi1_r, hphi2_r, hlast, hreset,
          dump_gate, sub_pulse, sof, sol;

    always #2.5 clk = ~clk;

    ccd_tgen #(.CNT_W(W), .N_LINES(NL), .PIX_SINGLE(PS), .PIX_DUAL(PD),
        .MIN_VSHIFT(F_VX), .MIN_HDELAY(F_HD), .MIN_XFER(F_PD), .MIN_FIRST(F_FIRST),
        .MIN_SHUT_W(F_SH), .MIN_SHUT_GUARD(F_SHQ)) u_ccd_tgen (.*);

    int checks = 0, errors = 0;
    bit finished = 0, clamp_run = 0, flush_req = 0;
    int e_vx, e_hd, e_pd, e_plead, e_ptail, e_first, e_fd, e_shd, e_sh, e_shq, e_half, e_npix;
    int sof_cnt = 0, sol_cnt = 0, li = -1;
    int ped_len = 0, x_len = 0, v_len = 0, f_len = 0, s_len = 0, h1_len = 0, h2_len = 0;
    int gap = 0, hg = 0, sg = 0, h1_rises = 0, rc = 0;
    bit gap_on = 0, hg_on = 0, sg_on = 0, cur_dump = 0, cur_shut = 0, fd_seen = 0, sub_seen = 0;
    bit p_h1 = 0;

    function automatic int fl(input int v, input int f);
        return (v < f) ? f : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s%s actual=%0d expected=%0d", tag,
                     clamp_run ? " (R11 clamp)" : "", act, exp);
        end
    endtask

    task end_line();
        chk("R6 pixels per line", h1_rises, e_npix);
        chk("R7 reset pulses per line", rc, e_npix);
        chk("R9 dump on this line", int'(fd_seen), int'(cur_dump));
        chk("R10 shutter on this line", int'(sub_seen), int'(cur_shut));
    endtask

    // Port monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (flush_req) begin
                if (li >= 0) end_line();
                li = -1; flush_req = 0;
            end
            if (sof) begin
                if (li >= 0) end_line();
                li = -1; sof_cnt++;
            end
            if (sol) begin
                if (li >= 0) end_line();
                li++; sol_cnt++;
                cur_dump = dump_en && li >= int'(dump_first) && li <= int'(dump_last);
                cur_shut = shut_en && li == int'(shut_line);
                h1_rises = 0; rc = 0; fd_seen = 0; sub_seen = 0;
            end
            if (gap_on) begin
                if (sol) begin chk("R3 first-line delay", gap, e_first); gap_on = 0; end
                else gap++;
            end
            if (hg_on) begin
                if (hphi1_l) begin
                    if (cur_shut)
                        chk("R10 shift-to-burst via shutter", hg,
                            (cur_dump ? e_fd : 0) + e_shd + e_sh + e_shq);
                    else if (cur_dump)
                        chk("R9 shift-to-burst after dump", hg, e_fd + e_hd);
                    else
                        chk("R5 shift-to-burst delay", hg, e_hd);
                    hg_on = 0;
                end else hg++;
            end
            if (sg_on) begin
                if (sub_pulse) begin
                    chk("R10 shutter start", sg, (cur_dump ? e_fd : 0) + e_shd);
                    sg_on = 0;
                end else sg++;
            end
            if (vphi1 && vphi2) ped_len++;
            else if (ped_len > 0) begin
                chk("R2 pedestal length", ped_len, e_plead + e_pd + e_ptail);
                ped_len = 0; gap_on = 1; gap = 1;
            end
            if (vphi2_xfer) x_len++;
            else if (x_len > 0) begin chk("R2 transfer pulse length", x_len, e_pd); x_len = 0; end
            if (vphi2 && !vphi1) v_len++;
            else if (v_len > 0) begin
                chk("R4 vertical shift length", v_len, e_vx);
                v_len = 0; hg_on = 1; hg = 1; sg_on = cur_shut; sg = 1;
            end
            if (dump_gate) begin f_len++; fd_seen = 1; end
            else if (f_len > 0) begin chk("R9 dump gate length", f_len, 2 * e_fd + e_vx); f_len = 0; end
            if (sub_pulse) begin s_len++; sub_seen = 1; end
            else if (s_len > 0) begin chk("R10 shutter width", s_len, e_sh); s_len = 0; end
            if (hphi1_l) begin h1_len++; if (!p_h1) h1_rises++; end
            else if (h1_len > 0) begin chk("R6 phase-1 half", h1_len, e_half); h1_len = 0; end
            if (hphi2_l) h2_len++;
            else if (h2_len > 0) begin chk("R6 phase-2 half", h2_len, e_half); h2_len = 0; end
            if (hreset) begin
                rc++;
                chk("R7 reset at pixel start", int'(hphi1_l && !p_h1), 1);
            end
            if (hphi1_l || hphi2_l || hphi1_r || hphi2_r) begin
                chk("R8 right-tap phases", int'({hphi1_r, hphi2_r}),
                    dual_tap ? int'({hphi2_l, hphi1_l}) : int'({hphi1_l, hphi2_l}));
                chk("R6 last stage follows phase 2", int'(hlast), int'(hphi2_l));
            end
            p_h1 = hphi1_l;
        end
    end

    task automatic set_expect();
        e_vx = fl(t_vshift, F_VX); e_hd = fl(t_hdelay, F_HD); e_pd = fl(t_xfer, F_PD);
        e_plead = fl(t_ped_lead, 1); e_ptail = fl(t_ped_tail, 1); e_first = fl(t_first, F_FIRST);
        e_fd = fl(t_dump_edge, 1); e_shd = fl(t_shut_delay, 1); e_sh = fl(t_shut_width, F_SH);
        e_shq = fl(t_shut_guard, F_SHQ); e_half = fl(t_pix_half, 1);
        e_npix = dual_tap ? PD : PS;
    endtask

    task automatic idle_check(input string tag);
        chk({tag, " vphi1 idle"}, int'(vphi1), 1);
        chk({tag, " others idle"}, int'({vphi2, vphi2_xfer, hphi1_l, hphi2_l, hphi1_r,
            hphi2_r, hlast, hreset, dump_gate, sub_pulse, sof, sol}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        idle_check("R1");
        repeat (20) @(negedge clk);
        chk("R1 no frame without run", sof_cnt, 0);
        idle_check("R1");

        // Run A: single tap, values above floors, dump line 1, shutter line 2.
        t_vshift = 5; t_hdelay = 4; t_xfer = 3; t_ped_lead = 2; t_ped_tail = 2; t_first = 6;
        t_dump_edge = 2; t_shut_delay = 2; t_shut_width = 3; t_shut_guard = 4; t_pix_half = 2;
        dual_tap = 0; dump_en = 1; dump_first = 1; dump_last = 1; shut_en = 1; shut_line = 2;
        set_expect();
        run = 1;
        wait (sof_cnt >= 2);
        @(negedge clk); run = 0;
        repeat (600) @(negedge clk);
        flush_req = 1;
        repeat (3) @(negedge clk);
        chk("R12 frames with run held", sof_cnt, 2);
        chk("R3 lines in two frames", sol_cnt, 2 * NL);
        idle_check("R12 stopped");

        // Run B: dual tap, all zero (floors), dump line 0, shutter last line.
        sof_cnt = 0; sol_cnt = 0; clamp_run = 1;
        t_vshift = 0; t_hdelay = 0; t_xfer = 0; t_ped_lead = 0; t_ped_tail = 0; t_first = 0;
        t_dump_edge = 0; t_shut_delay = 0; t_shut_width = 0; t_shut_guard = 0; t_pix_half = 0;
        dual_tap = 1; dump_en = 1; dump_first = 0; dump_last = 0; shut_en = 1; shut_line = 3;
        set_expect();
        run = 1;
        wait (sof_cnt >= 1);
        @(negedge clk); run = 0;
        repeat (400) @(negedge clk);
        flush_req = 1;
        repeat (3) @(negedge clk);
        chk("R12 single frame after early stop", sof_cnt, 1);
        chk("R3 lines in one frame", sol_cnt, NL);
        idle_check("R12 stopped");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule